// File: doc/BRIEF.md
# Register-Pair Word ALU

This block performs 16-bit arithmetic on a register pair in which Y holds the high byte and A the low byte. The second operand is a 16-bit word that arrives already fetched, as a low byte and a high byte. The operations are word add, word subtract, word compare, word increment, word decrement, word load, and an 8×8 unsigned multiply of Y by A.

The caller presents one operation per cycle together with the current register values and flags, and raises `in_valid`. One clock later the block returns the new Y and A, the flag set, and, for increment and decrement, a 16-bit value with a strobe to write back to memory.

Flag vector layout, used on `flags_in` and `flags_out`: bit 4 = N, bit 3 = V, bit 2 = H, bit 1 = Z, bit 0 = C. Operation codes on `op`: 0 add, 1 subtract, 2 compare, 3 increment, 4 decrement, 5 load, 6 multiply, 7 reserved.

Top module: `ya_word_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `y_out`, `a_out`, `wb_data`, `wb_en` and `flags_out` all become zero.
- R2: A result appears on the outputs, with `out_valid` high, exactly one clock after the operation is accepted with `in_valid` high. `out_valid` is low one clock after a cycle in which `in_valid` was low.
- R3: Add (op 0) adds `opnd_lo` to A. It then adds Y, `opnd_hi` and the low-byte carry to form the new Y. C is the carry out of bit 15.
- R4: For add, H is bit 4 of (operand high byte xor Y xor result high byte), which is the carry into bit 12. V is the signed overflow of the high-byte addition.
- R5: Subtract (op 1) adds the full two's complement of the operand: both bytes are inverted and 1 is added at the low byte, so an operand low byte of zero carries into the high byte. It then follows the add path, with H and V taken from the inverted high byte. C is 1 exactly when YA is greater than or equal to the operand.
- R6: Compare (op 2) evaluates YA minus the operand. It sets N, Z and C (C=1 when there is no borrow). It returns Y, A, V and H unchanged and does not write back.
- R7: For every word operation and for multiply, N is bit 15 of the 16-bit result and Z is 1 only when all 16 bits are zero. For example, a result of 0x0100 gives Z=0.
- R8: Increment (op 3) and decrement (op 4) put the operand ±1, modulo 65536, on `wb_data` and raise `wb_en`. They update only N and Z, and Y and A pass through unchanged.
- R9: Load (op 5) sets Y to `opnd_hi` and A to `opnd_lo`, and sets N and Z from that word. C, V and H pass through unchanged.
- R10: Multiply (op 6) places the unsigned product of Y and A with its high byte in Y and its low byte in A. N and Z come from the 16-bit product. C, V and H pass through unchanged.
- R11: The reserved code (op 7) returns Y, A and the flags unchanged, with `wb_en` low and `wb_data` zero.
- R12: While `in_valid` is low, `y_out`, `a_out`, `wb_data`, `wb_en` and `flags_out` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 3 | Operation code |
| y_in | input | BW | Current Y (high byte of pair) |
| a_in | input | BW | Current A (low byte of pair) |
| opnd_lo | input | BW | Operand low byte |
| opnd_hi | input | BW | Operand high byte |
| flags_in | input | 5 | Current flags {N,V,H,Z,C} |
| out_valid | output | 1 | Result valid |
| y_out | output | BW | New Y |
| a_out | output | BW | New A |
| wb_data | output | 2*BW | Word to write back to memory |
| wb_en | output | 1 | Write-back strobe |
| flags_out | output | 5 | New flags {N,V,H,Z,C} |

## Verification
In any single cycle, the arithmetic result and the pass-through of unaffected flags must both resolve: compare, increment, decrement, load and multiply compute a new 16-bit value while copying V, H (and for some, C) from the `flags_in` of that same cycle. The bench provokes this by issuing back-to-back operations whose `flags_in` differ from cycle to cycle. A mix-up between cycles or a wrongly overwritten flag therefore shows up as a scoreboard mismatch. Carry across the byte boundary during subtract, with an operand low byte of zero, is exercised in the same stream.

// File: rtl/ya_alu_pkg.sv
package ya_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADDW = 3'd0,
    OP_SUBW = 3'd1,
    OP_CMPW = 3'd2,
    OP_INCW = 3'd3,
    OP_DECW = 3'd4,
    OP_LDW  = 3'd5,
    OP_MUL  = 3'd6,
    OP_RSV  = 3'd7
  } ya_op_e;

  localparam int FLAG_W = 5;
  localparam int FL_C   = 0;
  localparam int FL_Z   = 1;
  localparam int FL_H   = 2;
  localparam int FL_V   = 3;
  localparam int FL_N   = 4;

endpackage

// File: rtl/ya_byte_addsub.sv
// Two-byte adder/subtractor: low byte first, its carry feeds the high byte.
module ya_byte_addsub #(
  parameter int BW = 8
) (
  input  logic [BW-1:0] hi_a,
  input  logic [BW-1:0] lo_a,
  input  logic [BW-1:0] hi_b,
  input  logic [BW-1:0] lo_b,
  input  logic          sub,
  output logic [BW-1:0] res_hi,
  output logic [BW-1:0] res_lo,
  output logic          carry,
  output logic          half,
  output logic          ovf
);
  localparam int HB = BW / 2;

  logic [BW-1:0] lo_b_eff;
  logic [BW-1:0] hi_b_eff;
  logic [BW:0]   lo_sum;
  logic [BW:0]   hi_sum;

  always_comb begin
    lo_b_eff = sub ? ~lo_b : lo_b;
    hi_b_eff = sub ? ~hi_b : hi_b;
    lo_sum   = {1'b0, lo_a} + {1'b0, lo_b_eff} + {{BW{1'b0}}, sub};
    hi_sum   = {1'b0, hi_a} + {1'b0, hi_b_eff} + {{BW{1'b0}}, lo_sum[BW]};
    res_lo   = lo_sum[BW-1:0];
    res_hi   = hi_sum[BW-1:0];
    carry    = hi_sum[BW];
    half     = hi_b_eff[HB] ^ hi_a[HB] ^ hi_sum[HB];
    ovf      = (hi_a[BW-1] == hi_b_eff[BW-1]) && (hi_sum[BW-1] != hi_a[BW-1]);
  end
endmodule

// File: rtl/ya_word_step.sv
// Word increment / decrement with wrap.
module ya_word_step #(
  parameter int WW = 16
) (
  input  logic [WW-1:0] word,
  input  logic          dec,
  output logic [WW-1:0] res
);
  always_comb begin
    if (dec) res = word - WW'(1);
    else     res = word + WW'(1);
  end
endmodule

// File: rtl/ya_mul.sv
// Unsigned shift-and-add multiplier, one partial-product stage per multiplier bit.
module ya_mul #(
  parameter int BW = 8
) (
  input  logic [BW-1:0]   mcand,
  input  logic [BW-1:0]   mplier,
  output logic [2*BW-1:0] prod
);
  localparam int PW = 2 * BW;

  logic [PW-1:0] acc [0:BW];

  assign acc[0] = '0;

  for (genvar i = 0; i < BW; i++) begin : g_pp
    logic [PW-1:0] term;
    assign term       = mplier[i] ? ({{BW{1'b0}}, mcand} << i) : '0;
    assign acc[i + 1] = acc[i] + term;
  end

  assign prod = acc[BW];
endmodule

// File: rtl/ya_word_alu.sv
module ya_word_alu
  import ya_alu_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic [BW-1:0]     y_in,
  input  logic [BW-1:0]     a_in,
  input  logic [BW-1:0]     opnd_lo,
  input  logic [BW-1:0]     opnd_hi,
  input  logic [FLAG_W-1:0] flags_in,
  output logic              out_valid,
  output logic [BW-1:0]     y_out,
  output logic [BW-1:0]     a_out,
  output logic [2*BW-1:0]   wb_data,
  output logic              wb_en,
  output logic [FLAG_W-1:0] flags_out
);
  localparam int WW = 2 * BW;

  ya_op_e op_e;
  assign op_e = ya_op_e'(op);

  // arithmetic path
  logic          as_sub;
  logic [BW-1:0] as_hi, as_lo;
  logic          as_c, as_h, as_v;

  assign as_sub = (op_e != OP_ADDW);

  ya_byte_addsub #(.BW(BW)) u_addsub (
    .hi_a   (y_in),
    .lo_a   (a_in),
    .hi_b   (opnd_hi),
    .lo_b   (opnd_lo),
    .sub    (as_sub),
    .res_hi (as_hi),
    .res_lo (as_lo),
    .carry  (as_c),
    .half   (as_h),
    .ovf    (as_v)
  );

  // increment / decrement path
  logic [WW-1:0] step_res;

  ya_word_step #(.WW(WW)) u_step (
    .word (({opnd_hi, opnd_lo})),
    .dec  ((op_e == OP_DECW)),
    .res  (step_res)
  );

  // multiply path
  logic [WW-1:0] mul_res;

  ya_mul #(.BW(BW)) u_mul (
    .mcand  (y_in),
    .mplier (a_in),
    .prod   (mul_res)
  );

  // result select
  logic [BW-1:0]     nx_y, nx_a;
  logic [WW-1:0]     nx_wb;
  logic              nx_wb_en;
  logic [FLAG_W-1:0] nx_f;
  logic [WW-1:0]     nz_src;
  logic              nz_upd;

  always_comb begin
    nx_y     = y_in;
    nx_a     = a_in;
    nx_wb    = '0;
    nx_wb_en = 1'b0;
    nx_f     = flags_in;
    nz_src   = '0;
    nz_upd   = 1'b0;
    unique case (op_e)
      OP_ADDW, OP_SUBW: begin
        nx_y       = as_hi;
        nx_a       = as_lo;
        nx_f[FL_C] = as_c;
        nx_f[FL_H] = as_h;
        nx_f[FL_V] = as_v;
        nz_src     = {as_hi, as_lo};
        nz_upd     = 1'b1;
      end
      OP_CMPW: begin
        nx_f[FL_C] = as_c;
        nz_src     = {as_hi, as_lo};
        nz_upd     = 1'b1;
      end
      OP_INCW, OP_DECW: begin
        nx_wb    = step_res;
        nx_wb_en = 1'b1;
        nz_src   = step_res;
        nz_upd   = 1'b1;
      end
      OP_LDW: begin
        nx_y   = opnd_hi;
        nx_a   = opnd_lo;
        nz_src = {opnd_hi, opnd_lo};
        nz_upd = 1'b1;
      end
      OP_MUL: begin
        nx_y   = mul_res[WW-1:BW];
        nx_a   = mul_res[BW-1:0];
        nz_src = mul_res;
        nz_upd = 1'b1;
      end
      default: begin
      end
    endcase
    if (nz_upd) begin
      nx_f[FL_N] = nz_src[WW-1];
      nx_f[FL_Z] = (nz_src == '0);
    end
  end

  // output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      y_out     <= '0;
      a_out     <= '0;
      wb_data   <= '0;
      wb_en     <= 1'b0;
      flags_out <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        y_out     <= nx_y;
        a_out     <= nx_a;
        wb_data   <= nx_wb;
        wb_en     <= nx_wb_en;
        flags_out <= nx_f;
      end
    end
  end
endmodule

// File: rtl/ya_word_alu_chk.sv
module ya_word_alu_chk
  import ya_alu_pkg::*;
#(
  parameter int BW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        op,
  input logic [BW-1:0]     y_in,
  input logic [BW-1:0]     a_in,
  input logic [BW-1:0]     opnd_lo,
  input logic [BW-1:0]     opnd_hi,
  input logic [FLAG_W-1:0] flags_in,
  input logic              out_valid,
  input logic [BW-1:0]     y_out,
  input logic [BW-1:0]     a_out,
  input logic [2*BW-1:0]   wb_data,
  input logic              wb_en,
  input logic [FLAG_W-1:0] flags_out
);

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_follows_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_cmp_keeps_ya_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_CMPW) |=>
      (y_out == $past(y_in)) && (a_out == $past(a_in)) && !wb_en &&
      (flags_out[FL_V] == $past(flags_in[FL_V])) &&
      (flags_out[FL_H] == $past(flags_in[FL_H])));

  p_nz_of_pair_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == OP_ADDW || op == OP_SUBW || op == OP_LDW || op == OP_MUL)) |=>
      (flags_out[FL_Z] == ({y_out, a_out} == '0)) && (flags_out[FL_N] == y_out[BW-1]));

  p_step_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == OP_INCW || op == OP_DECW)) |=>
      wb_en && (y_out == $past(y_in)) && (a_out == $past(a_in)) &&
      (flags_out[FL_C] == $past(flags_in[FL_C])) &&
      (flags_out[FL_V] == $past(flags_in[FL_V])) &&
      (flags_out[FL_H] == $past(flags_in[FL_H])) &&
      (flags_out[FL_Z] == (wb_data == '0)));

  p_load_copies_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_LDW) |=>
      ({y_out, a_out} == {$past(opnd_hi), $past(opnd_lo)}));

  p_reserved_inert_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_RSV) |=>
      (y_out == $past(y_in)) && (a_out == $past(a_in)) &&
      (flags_out == $past(flags_in)) && !wb_en);

  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(y_out) && $stable(a_out) && $stable(wb_data) &&
                  $stable(wb_en) && $stable(flags_out));

endmodule

bind ya_word_alu ya_word_alu_chk #(.BW(BW)) u_chk (.*);

// File: tb/tb_ya_word_alu.sv
`timescale 1ns/1ps
module tb_ya_word_alu;
  localparam int BW = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [7:0]  y_in = '0, a_in = '0, opnd_lo = '0, opnd_hi = '0;
  logic [4:0]  flags_in = '0;
  logic        out_valid;
  logic [7:0]  y_out, a_out;
  logic [15:0] wb_data;
  logic        wb_en;
  logic [4:0]  flags_out;

  always #10 clk = ~clk;

  ya_word_alu #(.BW(BW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .y_in(y_in), .a_in(a_in), .opnd_lo(opnd_lo), .opnd_hi(opnd_hi),
    .flags_in(flags_in), .out_valid(out_valid), .y_out(y_out), .a_out(a_out),
    .wb_data(wb_data), .wb_en(wb_en), .flags_out(flags_out)
  );

  typedef struct {
    logic [7:0]  y;
    logic [7:0]  a;
    logic [15:0] wb;
    logic        wb_en;
    logic [4:0]  f;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t last;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   mon_on = 0;
  bit   done = 0;

  // flag bits: 4 N, 3 V, 2 H, 1 Z, 0 C
  function automatic exp_t model(input int opi, input logic [7:0] y, input logic [7:0] a,
                                 input logic [7:0] lo, input logic [7:0] hi,
                                 input logic [4:0] f, input string tag);
    exp_t e;
    int ya, od, r, lo9, hi9;
    logic [7:0] hb;
    e.y = y; e.a = a; e.wb = '0; e.wb_en = 1'b0; e.f = f; e.tag = tag;
    ya = int'({y, a});
    od = int'({hi, lo});
    case (opi)
      0, 1: begin
        hb  = (opi == 1) ? ~hi : hi;
        lo9 = int'(a) + ((opi == 1) ? (int'(8'(~lo)) + 1) : int'(lo));
        hi9 = int'(y) + int'(hb) + (lo9 >> 8);
        r   = ((hi9 & 255) << 8) | (lo9 & 255);
        e.y = 8'(hi9);
        e.a = 8'(lo9);
        e.f[0] = (opi == 0) ? hi9[8] : (ya >= od);
        e.f[2] = ((int'(hb) ^ int'(y) ^ hi9) >> 4) & 1;
        e.f[3] = (y[7] == hb[7]) && (hi9[7] != y[7]);
        e.f[4] = r[15];
        e.f[1] = (r == 0);
      end
      2: begin
        r = (ya - od) & 16'hFFFF;
        e.f[0] = (ya >= od);
        e.f[4] = r[15];
        e.f[1] = (r == 0);
      end
      3, 4: begin
        r = (opi == 3) ? ((od + 1) & 16'hFFFF) : ((od + 65535) & 16'hFFFF);
        e.wb = 16'(r);
        e.wb_en = 1'b1;
        e.f[4] = r[15];
        e.f[1] = (r == 0);
      end
      5: begin
        e.y = hi; e.a = lo;
        e.f[4] = od[15];
        e.f[1] = (od == 0);
      end
      6: begin
        r = int'(y) * int'(a);
        e.y = 8'(r >> 8); e.a = 8'(r);
        e.f[4] = r[15];
        e.f[1] = (r == 0);
      end
      default: ;
    endcase
    return e;
  endfunction

  task automatic send(input int opi, input logic [7:0] y, input logic [7:0] a,
                      input logic [15:0] od, input logic [4:0] f, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    op       = 3'(opi);
    y_in     = y;
    a_in     = a;
    opnd_hi  = od[15:8];
    opnd_lo  = od[7:0];
    flags_in = f;
    q.push_back(model(opi, y, a, od[7:0], od[15:8], f, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op       = 3'($urandom_range(0, 7));
      y_in     = 8'($urandom);
      a_in     = 8'($urandom);
      flags_in = 5'($urandom);
    end
  endtask

  task automatic compare(input exp_t e);
    n_chk++;
    if (y_out !== e.y || a_out !== e.a || wb_data !== e.wb ||
        wb_en !== e.wb_en || flags_out !== e.f) begin
      n_bad++;
      $display("FAIL %s: got y=%h a=%h wb=%h wbe=%b f=%b exp y=%h a=%h wb=%h wbe=%b f=%b",
               e.tag, y_out, a_out, wb_data, wb_en, flags_out,
               e.y, e.a, e.wb, e.wb_en, e.f);
    end
  endtask

  // monitor / scoreboard
  always begin
    @(negedge clk);
    #1;
    if (mon_on && !rst) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R2: result with no pending item got=1 exp=0");
        end else begin
          exp_t e;
          e = q.pop_front();
          compare(e);
          last = e;
        end
      end else begin
        exp_t h;
        h = last;
        h.tag = "R12 hold";
        compare(h);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    n_chk++;
    if (out_valid !== 1'b0 || y_out !== 8'h00 || a_out !== 8'h00 || wb_data !== 16'h0 ||
        wb_en !== 1'b0 || flags_out !== 5'h00) begin
      n_bad++;
      $display("FAIL R1: got v=%b y=%h a=%h wb=%h wbe=%b f=%b exp all zero",
               out_valid, y_out, a_out, wb_data, wb_en, flags_out);
    end
    rst = 1'b0;
    last = '{y: 8'h0, a: 8'h0, wb: 16'h0, wb_en: 1'b0, f: 5'h0, tag: "R12"};
    mon_on = 1;
    idle(1);

    // add
    send(0, 8'h12, 8'h34, 16'h0101, 5'b00000, "R3 add basic");
    send(0, 8'h00, 8'hFF, 16'h0001, 5'b00000, "R3 add low carry");
    send(0, 8'hFF, 8'hFF, 16'h0001, 5'b00000, "R3 add carry out/Z");
    send(0, 8'h0F, 8'h00, 16'h0100, 5'b00000, "R4 add half");
    send(0, 8'h7F, 8'h00, 16'h0100, 5'b00000, "R4 add overflow");
    send(0, 8'h80, 8'h00, 16'h8000, 5'b11111, "R4 add neg overflow");
    // subtract
    send(1, 8'h10, 8'h00, 16'h0001, 5'b00000, "R5 sub borrow chain");
    send(1, 8'h00, 8'h00, 16'h0001, 5'b00001, "R5 sub underflow");
    send(1, 8'h35, 8'h77, 16'h1200, 5'b00000, "R5 sub low zero");
    send(1, 8'h80, 8'h00, 16'h0001, 5'b00000, "R5 sub overflow");
    // compare with preserved V/H in back-to-back flag mix
    send(2, 8'h12, 8'h34, 16'h1234, 5'b01100, "R6 cmp equal");
    send(2, 8'h00, 8'h10, 16'h0020, 5'b01000, "R6 cmp less");
    send(2, 8'h90, 8'h00, 16'h1000, 5'b00100, "R6 cmp greater");
    // N/Z on whole word
    send(0, 8'h00, 8'h80, 16'h0080, 5'b00000, "R7 Z whole word");
    send(6, 8'h10, 8'h10, 16'h0000, 5'b00010, "R7 mul 0x0100");
    // inc/dec
    send(3, 8'hAA, 8'hBB, 16'hFFFF, 5'b01101, "R8 inc wrap");
    send(4, 8'hAA, 8'hBB, 16'h0000, 5'b00110, "R8 dec wrap");
    send(4, 8'h01, 8'h02, 16'h0100, 5'b11011, "R8 dec borrow");
    send(3, 8'h01, 8'h02, 16'h00FF, 5'b00000, "R8 inc carry");
    // load
    send(5, 8'h11, 8'h22, 16'h8000, 5'b01101, "R9 load neg");
    send(5, 8'h11, 8'h22, 16'h0000, 5'b00000, "R9 load zero");
    // multiply
    send(6, 8'hFF, 8'hFF, 16'h0000, 5'b01101, "R10 mul max");
    send(6, 8'h00, 8'h37, 16'h0000, 5'b00000, "R10 mul zero");
    send(6, 8'h0C, 8'h0B, 16'h1234, 5'b10110, "R10 mul small");
    // reserved
    send(7, 8'h5A, 8'hA5, 16'hFFFF, 5'b10101, "R11 reserved");
    idle(3);
    // single op then gap: latency and hold
    send(0, 8'h01, 8'h01, 16'h0101, 5'b00000, "R2 single latency");
    idle(4);
    // mixed stream
    for (int i = 0; i < 60; i++) begin
      send(int'($urandom_range(0, 7)), 8'($urandom), 8'($urandom), 16'($urandom),
           5'($urandom), "R3 R5 R8 R10 mixed");
      if (i % 7 == 3) idle(2);
    end
    idle(4);
    if (q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R2: got %0d pending exp 0", q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule